// File: doc/BRIEF.md
# Split Static/Dynamic Memory Access Sequencer

This block sits between a processor core and two memory back-ends: a fast on-chip static RAM and an external dynamic-RAM controller. The core hands it one 16-bit word access at a time. Each access carries a word address (the byte address shifted right by one), a write flag, write data and a resume tag. The tag names the core state that should run once the access has finished.

The sequencer compares the word address with the size of the static region and sends the access down one of two paths. The static path drives a one-cycle read or write strobe and latches the read word straight from the RAM bus in the next cycle. The dynamic path runs a request/busy/ready handshake with the controller. In both cases the block ends with a one-cycle completion pulse that carries the tag back and presents any read data. While a dynamic access is pending, a wait flag tells the core to stall.

With default parameters, the static region covers the lowest 40 KB (20480 words). The 24-bit word address then spans 32 MB in total.

Top module: `dual_mem_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `done`, `sdram_wait`, `sram_rd`, `sram_wr`, `sd_rd_en` and `sd_wr_en` are all 0.
- R2: An access whose word address is below `SRAM_WORDS` goes to the static RAM. Any address equal to or above `SRAM_WORDS` goes to the dynamic-RAM controller.
- R3: A request (`req_valid` high) is accepted only at a clock edge where `req_ready` is 1. A request raised while an access is in progress is ignored and has no effect on either memory.
- R4: A static access asserts `sram_rd` (read) or `sram_wr` (write) for exactly one cycle, in the cycle after acceptance, with `sram_addr` and `sram_wdata` holding the request. The read word is taken from `sram_rdata` at the end of the following cycle, and `done` rises in the third cycle after acceptance.
- R5: A dynamic read drives `sd_addr` and holds `sd_rd_en` high until a clock edge at which `sd_busy` is 1. `sd_rd_en` is low from the next cycle on.
- R6: During a dynamic read's wait phase, `sd_rdata` is captured only at an edge where `sd_rd_ready` is 1. `done` follows in the next cycle, with that word on `rdata`.
- R7: A dynamic write holds `sd_addr`, `sd_wdata` and `sd_wr_en` together until an edge where `sd_busy` is 1. It then drops `sd_wr_en` and waits for an edge with `sd_busy` at 0, and `done` follows in the next cycle.
- R8: `done` is a one-cycle pulse. During it, `done_tag` equals the tag given with the request and, for reads, `rdata` holds the word read. `req_ready` is 1 in the cycle after `done`.
- R9: `sdram_wait` is 1 in every cycle of a dynamic access's request and wait phases, and 0 in all other cycles.
- R10: `sd_rd_en` and `sd_wr_en` are never 1 in the same cycle, and neither are `sram_rd` and `sram_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_tag | input | TAGW | Resume tag returned on completion |
| req_ready | output | 1 | Idle, able to take a request |
| done | output | 1 | Completion pulse |
| done_tag | output | TAGW | Tag of the completed access |
| rdata | output | DW | Read data holding register |
| sdram_wait | output | 1 | Dynamic access pending, core should stall |
| sram_addr | output | AW | Static RAM word address |
| sram_wdata | output | DW | Static RAM write data |
| sram_rd | output | 1 | Static RAM read strobe |
| sram_wr | output | 1 | Static RAM write strobe |
| sram_rdata | input | DW | Static RAM read bus |
| sd_addr | output | AW | Dynamic controller word address |
| sd_wdata | output | DW | Dynamic controller write data |
| sd_rd_en | output | 1 | Dynamic read enable |
| sd_wr_en | output | 1 | Dynamic write enable |
| sd_busy | input | 1 | Controller busy |
| sd_rd_ready | input | 1 | Controller read data valid pulse |
| sd_rdata | input | DW | Controller read data |

## Verification
The bench builds the block with AW=12 and SRAM_WORDS=64, with DW=16 and TAGW=4. Both back-end models can then be plain arrays, and the static/dynamic boundary at words 63 and 64, as well as the top word 4095, can be reached directly. Because 64 is a power of two, the bench exercises the upper-bits decode variant. The default 20480-word region takes the magnitude-compare variant. The dynamic responder's acknowledge delay is varied per access, from zero to several cycles, so that the request phase is held for one or many cycles. A request injected in the middle of a dynamic access shows that a busy sequencer ignores it.

// File: rtl/dms_pkg.sv
package dms_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2,
    PH_DONE = 2'd3
  } ph_t;
endpackage

// File: rtl/dms_rst_sync.sv
module dms_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/dms_decode.sv
module dms_decode #(
  parameter int AW         = 24,
  parameter int SRAM_WORDS = 20480
) (
  input  logic [AW-1:0] addr,
  output logic          is_sd
);
  localparam bit POW2 = (SRAM_WORDS & (SRAM_WORDS - 1)) == 0;
  localparam int LOG2 = $clog2(SRAM_WORDS);

  generate
    if (POW2 && LOG2 > 0 && LOG2 < AW) begin : g_upper_bits
      assign is_sd = |addr[AW-1:LOG2];
    end else begin : g_compare
      localparam logic [AW-1:0] LIMIT = AW'(SRAM_WORDS);
      assign is_sd = (addr >= LIMIT);
    end
  endgenerate
endmodule

// File: rtl/dms_ctrl.sv
module dms_ctrl
  import dms_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [TAGW-1:0] req_tag,
  input  logic            req_is_sd,
  input  logic            sd_busy,
  input  logic            sd_rd_ready,
  output logic            req_ready,
  output logic            done,
  output logic [TAGW-1:0] done_tag,
  output logic            sdram_wait,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            sram_rd,
  output logic            sram_wr,
  output logic            sd_rd_en,
  output logic            sd_wr_en,
  output logic            cap_en,
  output logic            cap_sel_sd
);
  ph_t             st_q, st_d;
  logic            wr_q, sd_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [TAGW-1:0] tag_q;
  logic            accept;

  assign accept = (st_q == PH_IDLE) && req_valid;

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE: if (req_valid) st_d = PH_REQ;
      PH_REQ:  if (!sd_q || sd_busy) st_d = PH_WAIT;
      PH_WAIT: begin
        if (!sd_q)                   st_d = PH_DONE;
        else if (!wr_q && sd_rd_ready) st_d = PH_DONE;
        else if (wr_q && !sd_busy)   st_d = PH_DONE;
      end
      PH_DONE: st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= PH_IDLE;
    else         st_q <= st_d;
  end

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wr_q    <= 1'b0;
      sd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      tag_q   <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      sd_q    <= req_is_sd;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      tag_q   <= req_tag;
    end
  end

  // outputs decoded from registered state
  always_comb begin
    req_ready  = (st_q == PH_IDLE);
    done       = (st_q == PH_DONE);
    sram_rd    = (st_q == PH_REQ) && !sd_q && !wr_q;
    sram_wr    = (st_q == PH_REQ) && !sd_q &&  wr_q;
    sd_rd_en   = (st_q == PH_REQ) &&  sd_q && !wr_q;
    sd_wr_en   = (st_q == PH_REQ) &&  sd_q &&  wr_q;
    sdram_wait = sd_q && ((st_q == PH_REQ) || (st_q == PH_WAIT));
    cap_sel_sd = sd_q;
    cap_en     = (st_q == PH_WAIT) && !wr_q && (!sd_q || sd_rd_ready);
  end

  assign done_tag = tag_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
endmodule

// File: rtl/dms_hold.sv
module dms_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          cap_en,
  input  logic          cap_sel_sd,
  input  logic [DW-1:0] sram_rdata,
  input  logic [DW-1:0] sd_rdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] hold_q, hold_d;

  always_comb hold_d = cap_sel_sd ? sd_rdata : sram_rdata;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     hold_q <= '0;
    else if (cap_en) hold_q <= hold_d;
  end

  assign rdata = hold_q;
endmodule

// File: rtl/dual_mem_seq.sv
module dual_mem_seq #(
  parameter int AW         = 24,
  parameter int DW         = 16,
  parameter int TAGW       = 4,
  parameter int SRAM_WORDS = 20480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [TAGW-1:0] req_tag,
  output logic            req_ready,
  output logic            done,
  output logic [TAGW-1:0] done_tag,
  output logic [DW-1:0]   rdata,
  output logic            sdram_wait,
  output logic [AW-1:0]   sram_addr,
  output logic [DW-1:0]   sram_wdata,
  output logic            sram_rd,
  output logic            sram_wr,
  input  logic [DW-1:0]   sram_rdata,
  output logic [AW-1:0]   sd_addr,
  output logic [DW-1:0]   sd_wdata,
  output logic            sd_rd_en,
  output logic            sd_wr_en,
  input  logic            sd_busy,
  input  logic            sd_rd_ready,
  input  logic [DW-1:0]   sd_rdata
);
  logic          rst_sn;
  logic          is_sd;
  logic          cap_en, cap_sel_sd;
  logic [AW-1:0] addr_w;
  logic [DW-1:0] wdata_w;

  dms_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  dms_decode #(.AW(AW), .SRAM_WORDS(SRAM_WORDS)) u_dec (
    .addr(req_addr), .is_sd(is_sd)
  );

  dms_ctrl #(.AW(AW), .DW(DW), .TAGW(TAGW)) u_ctrl (
    .clk(clk), .rst_sn(rst_sn),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_tag(req_tag), .req_is_sd(is_sd),
    .sd_busy(sd_busy), .sd_rd_ready(sd_rd_ready),
    .req_ready(req_ready), .done(done), .done_tag(done_tag),
    .sdram_wait(sdram_wait), .addr_o(addr_w), .wdata_o(wdata_w),
    .sram_rd(sram_rd), .sram_wr(sram_wr),
    .sd_rd_en(sd_rd_en), .sd_wr_en(sd_wr_en),
    .cap_en(cap_en), .cap_sel_sd(cap_sel_sd)
  );

  dms_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_sn(rst_sn), .cap_en(cap_en), .cap_sel_sd(cap_sel_sd),
    .sram_rdata(sram_rdata), .sd_rdata(sd_rdata), .rdata(rdata)
  );

  assign sram_addr  = addr_w;
  assign sram_wdata = wdata_w;
  assign sd_addr    = addr_w;
  assign sd_wdata   = wdata_w;
endmodule

// File: rtl/dms_checker.sv
module dms_checker #(
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int TAGW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            done,
  input logic            sdram_wait,
  input logic            sram_rd,
  input logic            sram_wr,
  input logic [AW-1:0]   sd_addr,
  input logic [DW-1:0]   sd_wdata,
  input logic            sd_rd_en,
  input logic            sd_wr_en,
  input logic            sd_busy
);
  // R10
  a_r10_sd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_rd_en && sd_wr_en));
  // R10
  a_r10_sram_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_rd && sram_wr));
  // R4: static strobes last one cycle
  a_r4_sram_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    sram_rd |=> !sram_rd);
  a_r4_sram_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr |=> !sram_wr);
  // R5
  a_r5_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_rd_en && !sd_busy) |=> (sd_rd_en && $stable(sd_addr)));
  a_r5_rd_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_rd_en && sd_busy) |=> !sd_rd_en);
  // R7
  a_r7_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_wr_en && !sd_busy) |=> (sd_wr_en && $stable(sd_addr) && $stable(sd_wdata)));
  a_r7_wr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_wr_en && sd_busy) |=> !sd_wr_en);
  // R8
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  // R9
  a_r9_wait_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_rd_en || sd_wr_en) |-> sdram_wait);
  a_r9_wait_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || done) |-> !sdram_wait);
endmodule

bind dual_mem_seq dms_checker #(.AW(AW), .DW(DW), .TAGW(TAGW)) u_chk (.*);

// File: tb/dual_mem_seq_tb_top.sv
module dual_mem_seq_tb_top;
  localparam int AW = 12, DW = 16, TAGW = 4, SRAM_WORDS = 64;
  localparam int NWORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic [TAGW-1:0] req_tag = '0;
  logic            req_ready, done, sdram_wait, sram_rd, sram_wr, sd_rd_en, sd_wr_en;
  logic [TAGW-1:0] done_tag;
  logic [DW-1:0]   rdata, sram_wdata, sd_wdata;
  logic [AW-1:0]   sram_addr, sd_addr;
  logic [DW-1:0]   sram_rdata, sd_rdata;
  logic            sd_busy, sd_rd_ready;

  dual_mem_seq #(.AW(AW), .DW(DW), .TAGW(TAGW), .SRAM_WORDS(SRAM_WORDS)) dut_i (.*);

  int vectors = 0, miscompares = 0;
  logic [DW-1:0] shadow [NWORDS];
  logic [DW-1:0] smem [SRAM_WORDS];
  logic [DW-1:0] dmem [NWORDS];

  function automatic logic [DW-1:0] seed_val(int a);
    return DW'((a * 16'h3b1) ^ 16'h5a5a);
  endfunction

  initial begin
    for (int i = 0; i < NWORDS; i++) begin
      shadow[i] = seed_val(i);
      dmem[i]   = seed_val(i);
    end
    for (int i = 0; i < SRAM_WORDS; i++) smem[i] = seed_val(i);
  end

  // static RAM: registered read, write on strobe
  always @(posedge clk) begin
    if (sram_rd) sram_rdata <= smem[sram_addr];
    if (sram_wr) smem[sram_addr] <= sram_wdata;
  end

  // dynamic controller responder
  int ack_dly = 0;
  int rs = 0, rcnt = 0;
  bit r_op_rd;
  logic [AW-1:0] r_a;
  logic [DW-1:0] r_d;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs <= 0; sd_busy <= 1'b0; sd_rd_ready <= 1'b0; sd_rdata <= '0;
    end else begin
      case (rs)
        0: if (sd_rd_en || sd_wr_en) begin
             r_op_rd <= sd_rd_en; r_a <= sd_addr; r_d <= sd_wdata;
             rcnt <= ack_dly; rs <= 1;
           end
        1: if (rcnt == 0) begin sd_busy <= 1'b1; rcnt <= 3; rs <= 2; end
           else rcnt <= rcnt - 1;
        2: if (rcnt == 0) begin
             sd_busy <= 1'b0;
             if (r_op_rd) begin sd_rdata <= dmem[r_a]; sd_rd_ready <= 1'b1; rs <= 3; end
             else begin dmem[r_a] <= r_d; rs <= 0; end
           end else rcnt <= rcnt - 1;
        default: begin sd_rd_ready <= 1'b0; rs <= 0; end
      endcase
    end
  end

  // behavioural reference model: 0 idle, 1 request, 2 wait, 3 done
  int            m_ph;
  bit            m_wr, m_sd;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rd;
  logic [TAGW-1:0] m_tag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_wr <= 0; m_sd <= 0; m_rd <= '0;
    end else begin
      case (m_ph)
        0: if (req_valid) begin
             m_ph <= 1; m_wr <= req_write; m_sd <= (int'(req_addr) >= SRAM_WORDS);
             m_addr <= req_addr; m_wdata <= req_wdata; m_tag <= req_tag;
           end
        1: if (!m_sd || sd_busy) m_ph <= 2;
        2: if (!m_sd) begin
             if (!m_wr) m_rd <= sram_rdata;
             m_ph <= 3;
           end else if (!m_wr) begin
             if (sd_rd_ready) begin m_rd <= sd_rdata; m_ph <= 3; end
           end else if (!sd_busy) m_ph <= 3;
        default: m_ph <= 0;
      endcase
    end
  end

  task automatic cmp(string req, string nm, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      cmp("R3", "req_ready", req_ready, m_ph == 0);
      cmp("R8", "done", done, m_ph == 3);
      cmp("R9", "sdram_wait", sdram_wait, m_sd && (m_ph == 1 || m_ph == 2));
      cmp("R4", "sram_rd", sram_rd, m_ph == 1 && !m_sd && !m_wr);
      cmp("R4", "sram_wr", sram_wr, m_ph == 1 && !m_sd && m_wr);
      cmp("R5", "sd_rd_en", sd_rd_en, m_ph == 1 && m_sd && !m_wr);
      cmp("R7", "sd_wr_en", sd_wr_en, m_ph == 1 && m_sd && m_wr);
      cmp("R10", "rd_wr_overlap", {sd_rd_en && sd_wr_en, sram_rd && sram_wr}, 0);
      if (m_ph == 1) begin
        cmp("R2", "addr", m_sd ? sd_addr : sram_addr, m_addr);
        if (m_wr) cmp("R7", "wdata", m_sd ? sd_wdata : sram_wdata, m_wdata);
      end
      if (m_ph == 3) begin
        cmp("R8", "done_tag", done_tag, m_tag);
        if (!m_wr) cmp("R6", "rdata", rdata, m_rd);
      end
    end
  end

  // one access, with independent end-to-end checks
  task automatic access(bit wr, int a, logic [DW-1:0] d, logic [TAGW-1:0] tg,
                        int ack, bit inject);
    int n;
    bit is_sd = (a >= SRAM_WORDS);
    ack_dly = ack;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_tag = tg;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    if (inject) begin
      // R3: request raised mid-access must be ignored
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a + 1); req_wdata = 16'hdead;
      req_tag = ~tg;
      @(negedge clk); n++;
      req_valid = 1'b0;
    end
    while (!done && n < 200) begin @(negedge clk); n++; end
    vectors++;
    if (!done) begin
      miscompares++;
      $display("FAIL R8 done: actual 0 expected 1 (addr %0d)", a);
    end
    cmp("R8", "done_tag_e2e", done_tag, tg);
    if (!is_sd) cmp("R4", "sram_latency", n, 3);
    if (!wr) cmp(is_sd ? "R6" : "R4", "rdata_e2e", rdata, shadow[a]);
    else shadow[a] = d;
    @(negedge clk);
    vectors++;
    cmp("R8", "ready_after_done", {req_ready, done}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    cmp("R1", "reset_outputs",
        {req_ready, done, sdram_wait, sram_rd, sram_wr, sd_rd_en, sd_wr_en}, 7'b1000000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    vectors++;
    cmp("R1", "idle_outputs",
        {req_ready, done, sdram_wait, sram_rd, sram_wr, sd_rd_en, sd_wr_en}, 7'b1000000);

    // R2/R4: static region, including the last static word
    access(0, 5, '0, 4'h1, 0, 0);
    access(1, 5, 16'h1234, 4'h2, 0, 0);
    access(0, 5, '0, 4'h3, 0, 0);
    access(1, SRAM_WORDS - 1, 16'hbeef, 4'h4, 0, 0);
    access(0, SRAM_WORDS - 1, '0, 4'h5, 0, 0);
    // R2/R5/R6: first dynamic word, acknowledge delays 0 and 4
    access(0, SRAM_WORDS, '0, 4'h6, 0, 0);
    access(0, SRAM_WORDS, '0, 4'h7, 4, 0);
    // R7: dynamic writes then readback
    access(1, SRAM_WORDS, 16'hc0de, 4'h8, 2, 0);
    access(0, SRAM_WORDS, '0, 4'h9, 1, 0);
    access(1, NWORDS - 1, 16'h7777, 4'ha, 5, 0);
    access(0, NWORDS - 1, '0, 4'hb, 0, 0);
    // R3: injected request during dynamic accesses has no effect
    access(0, 1000, '0, 4'hc, 3, 1);
    access(1, 2000, 16'h0f0f, 4'hd, 3, 1);
    access(0, 1001, '0, 4'he, 0, 0);
    access(0, 2001, '0, 4'hf, 0, 0);
    access(0, 2000, '0, 4'h0, 2, 0);
    // back-to-back mixed pattern
    for (int i = 0; i < 20; i++)
      access(i[0], (i * 397) % NWORDS, DW'(i * 16'h1111), TAGW'(i), i % 5, 0);
    for (int i = 0; i < 20; i++)
      access(0, (i * 397) % NWORDS, '0, TAGW'(i + 3), (i + 2) % 4, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule